// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block is the landing point for message-signalled interrupt writes on a memory-mapped slave bus. Its 2048 pending vector bits sit in 16 groups. Each group holds 8 vector registers of 16 bits each. A write to a vector register carries a small number in its data, and that number picks which bit of the register to set. The interrupt service routine first reads the group's read-only summary register, which has one bit for each vector register that holds any pending bit. It then reads the vector registers that the summary names. Each such read returns the pending bits and clears them in the same access.

Each group drives its own interrupt line, so 16 lines in all. A line stays high for as long as anything in its group is pending. The bus has a 24-bit byte address, 32-bit write and read data, and separate write and read strobes. Read data appears on the cycle after the read strobe and holds until the next read. The asynchronous active-low reset is released synchronously inside the block.

Top module: `msi_term_bank`

## Requirements
- R1: Reset clears every pending bit, drives all 16 interrupt lines low and sets the read data to zero.
- R2: The vector register for group g (0..15) and index x (0..7) answers at byte address (g << 19) + (x << 16). Address bit 23 must be 0 and bits 15:0 must be 0.
- R3: The summary register of group g answers at byte address 0x800000 + (g << 16), with bits 22:20 and 15:0 zero. Its read data bit x is 1 exactly when vector register x of that group holds a pending bit. Read data bits 31:8 are zero.
- R4: A write of value v (0..15) to a vector register sets bit v of that register. Bits that are already set stay set.
- R5: A read of a vector register returns its pending bits in read data bits 15:0, with bits 31:16 zero, on the cycle after the read strobe. The read clears the register.
- R6: Interrupt line g is high exactly while some vector register of group g holds a pending bit. It rises on the cycle after the write that sets the first bit.
- R7: When a set-write and a clearing read hit the same vector register in the same cycle, the read returns the old contents and the newly written bit remains set afterwards.
- R8: A write whose data is 16 or more, or whose address matches no vector register, changes no pending bit.
- R9: A read of an address that matches no register returns zero and clears nothing.
- R10: Reading a summary register has no side effect, and writes to a summary register are ignored.
- R11: Groups are independent: setting or clearing bits in one group leaves every other group's bits and interrupt line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data (vector number) |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 16 | Per-group interrupt lines |

## Verification
The bench sets a bit and reads the same register in one cycle. A design that lets the clear win would lose that interrupt, and the second read would come back empty. It writes out-of-range vector numbers such as 16 and 0x100. A decoder that keeps only the low bits would set bit 0, and the line would rise. It writes to the summary address and to addresses with stray low bits set, and it reads unmapped and summary addresses while bits are pending. A design that decodes loosely or clears on a summary read would show a changed line or nonzero data. It sets bits in the first and last groups and in several indices of one group, so that a mix-up in the field order would land bits in the wrong summary position.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;

  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_INDEX   = 2'd1,
    ACC_SUMMARY = 2'd2
  } msi_acc_e;

endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_s_n = sync_q;

endmodule

// File: rtl/msi_addr_dec.sv
module msi_addr_dec
  import msi_term_pkg::*;
#(
  parameter int NUM_GRP     = 16,
  parameter int IDX_PER_GRP = 8,
  parameter int VEC_PER_IDX = 16,
  parameter int IDX_SHIFT   = 16,
  parameter int DATA_W      = 32,
  localparam int GRP_W      = $clog2(NUM_GRP),
  localparam int IDX_W      = $clog2(IDX_PER_GRP),
  localparam int VEC_W      = $clog2(VEC_PER_IDX),
  localparam int GRP_SHIFT  = IDX_SHIFT + IDX_W,
  localparam int SUM_BIT    = GRP_SHIFT + GRP_W,
  localparam int ADDR_W     = SUM_BIT + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output msi_acc_e          acc,
  output logic [GRP_W-1:0]  grp,
  output logic [IDX_W-1:0]  idx,
  output logic              data_ok,
  output logic [VEC_W-1:0]  vec_sel
);

  logic low_clear;
  logic sum_pad_clear;

  always_comb begin
    low_clear     = (addr[IDX_SHIFT-1:0] == '0);
    sum_pad_clear = (addr[SUM_BIT-1:IDX_SHIFT+GRP_W] == '0);
    acc = ACC_NONE;
    grp = '0;
    idx = '0;
    if (low_clear && !addr[SUM_BIT]) begin
      acc = ACC_INDEX;
      grp = addr[GRP_SHIFT +: GRP_W];
      idx = addr[IDX_SHIFT +: IDX_W];
    end else if (low_clear && addr[SUM_BIT] && sum_pad_clear) begin
      acc = ACC_SUMMARY;
      grp = addr[IDX_SHIFT +: GRP_W];
    end
    data_ok = (wdata[DATA_W-1:VEC_W] == '0);
    vec_sel = wdata[VEC_W-1:0];
  end

endmodule

// File: rtl/msi_idx_reg.sv
module msi_idx_reg #(
  parameter int VEC_PER_IDX = 16,
  localparam int VEC_W      = $clog2(VEC_PER_IDX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic [VEC_W-1:0]       set_sel,
  input  logic                   rd_clr,
  output logic [VEC_PER_IDX-1:0] bits_q
);

  logic [VEC_PER_IDX-1:0] bits_d;
  logic [VEC_PER_IDX-1:0] set_mask;
  logic                   bits_en;

  always_comb begin
    set_mask = '0;
    if (set_en) set_mask[set_sel] = 1'b1;
    bits_en = set_en | rd_clr;
    bits_d  = (rd_clr ? '0 : bits_q) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (bits_en) bits_q <= bits_d;
  end

  AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bits_q[$past(set_sel)]); // R7

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_en) |=> (bits_q == '0)); // R5

endmodule

// File: rtl/msi_group.sv
module msi_group #(
  parameter int IDX_PER_GRP = 8,
  parameter int VEC_PER_IDX = 16,
  localparam int IDX_W      = $clog2(IDX_PER_GRP),
  localparam int VEC_W      = $clog2(VEC_PER_IDX),
  localparam int FLAT_W     = IDX_PER_GRP * VEC_PER_IDX
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   grp_wr,
  input  logic                   grp_rd,
  input  logic [IDX_W-1:0]       idx,
  input  logic [VEC_W-1:0]       vec_sel,
  output logic [FLAT_W-1:0]      bits_flat,
  output logic [IDX_PER_GRP-1:0] summary,
  output logic                   irq
);

  for (genvar x = 0; x < IDX_PER_GRP; x++) begin : g_idx
    logic hit;
    logic [VEC_PER_IDX-1:0] q;
    assign hit = (idx == IDX_W'(x));

    msi_idx_reg #(.VEC_PER_IDX(VEC_PER_IDX)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (grp_wr & hit),
      .set_sel (vec_sel),
      .rd_clr  (grp_rd & hit),
      .bits_q  (q)
    );

    assign bits_flat[x*VEC_PER_IDX +: VEC_PER_IDX] = q;
    assign summary[x] = |q;
  end

  assign irq = |summary;

  AST_GROUP_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_wr |=> irq); // R6

endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_term_pkg::*;
#(
  parameter int NUM_GRP     = 16,
  parameter int IDX_PER_GRP = 8,
  parameter int VEC_PER_IDX = 16,
  parameter int IDX_SHIFT   = 16,
  parameter int DATA_W      = 32,
  localparam int GRP_W      = $clog2(NUM_GRP),
  localparam int IDX_W      = $clog2(IDX_PER_GRP),
  localparam int VEC_W      = $clog2(VEC_PER_IDX),
  localparam int FLAT_W     = IDX_PER_GRP * VEC_PER_IDX,
  localparam int ADDR_W     = IDX_SHIFT + IDX_W + GRP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_GRP-1:0] irq
);

  logic             rst_s_n;
  msi_acc_e         acc;
  logic [GRP_W-1:0] grp;
  logic [IDX_W-1:0] idx;
  logic             data_ok;
  logic [VEC_W-1:0] vec_sel;
  logic             set_ok;
  logic             clr_ok;

  logic [FLAT_W-1:0]      grp_bits [NUM_GRP];
  logic [IDX_PER_GRP-1:0] grp_sum  [NUM_GRP];

  logic [VEC_PER_IDX-1:0] sel_bits;
  logic [IDX_PER_GRP-1:0] sel_sum;
  logic [DATA_W-1:0]      rdata_d;
  logic [DATA_W-1:0]      rdata_q;
  logic                   rdata_en;

  msi_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  msi_addr_dec #(
    .NUM_GRP     (NUM_GRP),
    .IDX_PER_GRP (IDX_PER_GRP),
    .VEC_PER_IDX (VEC_PER_IDX),
    .IDX_SHIFT   (IDX_SHIFT),
    .DATA_W      (DATA_W)
  ) u_dec (
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .acc     (acc),
    .grp     (grp),
    .idx     (idx),
    .data_ok (data_ok),
    .vec_sel (vec_sel)
  );

  always_comb begin
    set_ok = bus_wr & data_ok & (acc == ACC_INDEX);
    clr_ok = bus_rd & (acc == ACC_INDEX);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic sel;
    assign sel = (grp == GRP_W'(g));

    msi_group #(
      .IDX_PER_GRP (IDX_PER_GRP),
      .VEC_PER_IDX (VEC_PER_IDX)
    ) u_group (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .grp_wr    (set_ok & sel),
      .grp_rd    (clr_ok & sel),
      .idx       (idx),
      .vec_sel   (vec_sel),
      .bits_flat (grp_bits[g]),
      .summary   (grp_sum[g]),
      .irq       (irq[g])
    );
  end

  always_comb begin
    sel_bits = grp_bits[grp][idx*VEC_PER_IDX +: VEC_PER_IDX];
    sel_sum  = grp_sum[grp];
    rdata_d  = '0;
    case (acc)
      ACC_INDEX:   rdata_d[VEC_PER_IDX-1:0] = sel_bits;
      ACC_SUMMARY: rdata_d[IDX_PER_GRP-1:0] = sel_sum;
      default:     rdata_d = '0;
    endcase
    rdata_en = bus_rd;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && !set_ok && !bus_rd) |=> $stable(irq)); // R8

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && acc == ACC_NONE) |=> (bus_rdata == '0)); // R9

  AST_SUMMARY_READ_PURE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && acc == ACC_SUMMARY && !bus_wr) |=> $stable(irq)); // R10

endmodule

// File: tb/msi_term_bank_bench.sv
module msi_term_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] mdl [16][8];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        mon_go = 1'b0;

  always #5 clk = ~clk;

  msi_term_bank u_msi_term_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  function automatic logic [23:0] ia(input int g, input int x);
    return 24'((g << 19) | (x << 16));
  endfunction

  function automatic logic [23:0] sa(input int g);
    return 24'(32'h80_0000 | (g << 16));
  endfunction

  function automatic logic [7:0] sum_of(input int g);
    logic [7:0] s;
    for (int x = 0; x < 8; x++) s[x] = (mdl[g][x] != 16'h0);
    return s;
  endfunction

  function automatic logic [15:0] irq_exp();
    logic [15:0] e;
    for (int g = 0; g < 16; g++) e[g] = (sum_of(g) != 8'h0);
    return e;
  endfunction

  task automatic clear_model();
    for (int g = 0; g < 16; g++)
      for (int x = 0; x < 8; x++) mdl[g][x] = 16'h0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic rd, input logic [23:0] a,
                    input logic [31:0] d, input string tag);
    logic idx_hit;
    logic sum_hit;
    int   g;
    int   x;
    logic [31:0] e;
    idx_hit = !a[23] && (a[15:0] == 16'h0);
    sum_hit = a[23] && (a[22:20] == 3'h0) && (a[15:0] == 16'h0);
    g = idx_hit ? int'(a[22:19]) : int'(a[19:16]);
    x = int'(a[18:16]);
    if (rd) begin
      e = 32'h0;
      if (idx_hit) e = {16'h0, mdl[g][x]};
      else if (sum_hit) e = {24'h0, sum_of(g)};
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (idx_hit) mdl[g][x] = 16'h0;
    end
    if (wr && idx_hit && d < 32'd16) mdl[g][x][d[3:0]] = 1'b1;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    check(tag, {16'h0, irq}, {16'h0, irq_exp()});
  endtask

  always @(posedge clk) mon_go <= bus_rd;

  always @(negedge clk) begin
    if (mon_go && exp_q.size() > 0) begin
      check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {16'h0, irq}, 32'h0);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_irq("R1 irq after reset");
    op(0, 1, ia(4, 3), 0, "R1 empty vector reg");

    op(1, 0, ia(0, 0), 5, "R4 set");
    chk_irq("R6 irq rises");
    op(0, 1, sa(0), 0, "R3 summary g0");
    op(0, 1, sa(0), 0, "R10 summary reread");
    chk_irq("R10 irq after summary read");

    op(1, 0, ia(3, 7), 15, "R4 set 15");
    op(1, 0, ia(3, 7), 0, "R4 set 0");
    op(1, 0, ia(3, 7), 15, "R4 reset same bit");
    chk_irq("R6 irq g3");
    op(0, 1, ia(3, 7), 0, "R2 R5 read g3x7");
    op(0, 1, ia(3, 7), 0, "R5 cleared");
    chk_irq("R6 irq g3 falls");

    op(1, 0, ia(15, 2), 9, "R11 set g15x2");
    op(1, 0, ia(15, 5), 3, "R11 set g15x5");
    op(0, 1, sa(15), 0, "R3 summary g15");
    op(0, 1, sa(14), 0, "R11 summary g14 empty");
    chk_irq("R11 irq g0 g15");

    op(1, 0, ia(1, 0), 16, "R8 data 16");
    op(1, 0, ia(1, 0), 32'h100, "R8 data 0x100");
    op(1, 0, ia(1, 0) | 24'h4, 2, "R8 stray low bits");
    op(1, 0, 24'h90_0000, 1, "R8 unmapped write");
    chk_irq("R8 irq unchanged");
    op(0, 1, ia(1, 0), 0, "R8 g1x0 empty");

    op(0, 1, ia(0, 0) | 24'h10, 0, "R9 unmapped read");
    op(0, 1, 24'hF0_0000, 0, "R9 unmapped high read");
    op(0, 1, sa(0), 0, "R9 nothing cleared");

    op(1, 0, sa(6), 3, "R10 summary write");
    op(0, 1, sa(6), 0, "R10 summary unchanged");
    chk_irq("R10 irq unchanged");

    op(1, 0, ia(2, 1), 4, "R7 prep");
    op(1, 1, ia(2, 1), 4, "R7 same bit read");
    op(0, 1, ia(2, 1), 0, "R7 bit survives");
    op(1, 0, ia(2, 1), 11, "R7 prep2");
    op(1, 1, ia(2, 1), 6, "R7 other bit read");
    op(0, 1, ia(2, 1), 0, "R7 new bit survives");

    op(0, 1, ia(0, 0), 0, "R5 drain g0");
    op(0, 1, ia(15, 2), 0, "R5 drain g15x2");
    chk_irq("R11 g15 still pending");
    op(0, 1, ia(15, 5), 0, "R5 drain g15x5");
    chk_irq("R6 all low");

    op(1, 0, ia(9, 4), 1, "R1 prep");
    @(negedge clk);
    rst_n = 1'b0;
    clear_model();
    @(negedge clk);
    check("R1 irq mid reset", {16'h0, irq}, 32'h0);
    check("R1 rdata mid reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    op(0, 1, ia(9, 4), 0, "R1 cleared by reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule